// File: doc/BRIEF.md
# Interrupt Priority Resolver with Source Promotion

This block picks one winner each cycle among a set of interrupt requests and presents it to the CPU as a pending flag and a 16-bit vector address. The inputs are the CPU's I and X mask bits, a set of internal maskable sources, an external active-low IRQ pin, an active-low XIRQ pin, and the non-maskable requests: clock monitor, watchdog, trap and software interrupt. Every maskable source owns a fixed even vector address on page $FF. By default a higher address means a higher priority. The IRQ pin sits at $FFF2, the highest maskable address. The internal sources follow downward two bytes apart, so source 0 (the real-time tick) sits at $FFF0.

Software can move one maskable source to the top of the maskable order. It does this by writing the low byte of that source's vector address into a promotion register. That register changes only while I is set. A value that names no implemented source falls back to the IRQ entry.

The IRQ pin has a write-once configuration. One bit sets the pin to falling-edge or low-level sensing, and another bit connects or disconnects the pin from the resolver. In edge mode a captured falling edge stays pending until the CPU acknowledges the IRQ vector.

Top module: `ipr_top`

## Requirements
- R1: After reset, pend is 0, vec is 0, prio_rd reads $F2, and cfg_rd reads 2'b10 (bit 1 = pin enabled, bit 0 = edge mode): the pin is enabled and level-sensitive.
- R2: Non-maskable requests rank as follows, from high to low: clock monitor ($FFFC), watchdog ($FFFA), trap ($FFF8), XIRQ ($FFF4), software interrupt ($FFF6).
- R3: An XIRQ request (xirq_pin_n low) is ignored while ccr_x is 1. Once ccr_x has been seen at 0, XIRQ cannot be masked again until reset.
- R4: Maskable requests are presented only while ccr_i is 0. Any active non-maskable request beats every maskable one.
- R5: Maskable entry j has vector $FF00 + ($F2 - 2j). Entry 0 is the IRQ pin and entry j+1 is src_req[j]. With no promotion, the pending entry with the highest address wins. Outputs are registered one cycle after the inputs, and vec is 0 whenever pend is 0.
- R6: A write to the promotion register takes effect only while ccr_i is 1. Only bits 7:1 are stored, so bit 0 always reads 0.
- R7: A written value above $F2, or below the lowest implemented entry address, stores $F2.
- R8: If the promoted entry is pending, it wins among maskable requests. Otherwise the order of R5 applies.
- R9: The first write to the IRQ configuration is kept. Every later write is ignored until reset.
- R10: In level mode the pin requests while it is low and enabled. When the pin is disabled, it never requests.
- R11: In edge mode a falling edge is latched. The latch survives the pin returning high and clears when ack is given while the output is $FFF2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_pin_n | input | 1 | External IRQ pin, active low |
| xirq_pin_n | input | 1 | External XIRQ pin, active low |
| src_req | input | NSRC | Internal maskable requests; bit 0 is the real-time tick |
| ccr_i | input | 1 | CPU I mask bit |
| ccr_x | input | 1 | CPU X mask bit |
| cm_req | input | 1 | Clock monitor failure request |
| cop_req | input | 1 | Watchdog timeout request |
| trap_req | input | 1 | Illegal opcode trap request |
| swi_req | input | 1 | Software interrupt request |
| ack | input | 1 | CPU takes the presented vector |
| prio_we | input | 1 | Promotion register write strobe |
| prio_wdata | input | 8 | Low byte of the vector to promote |
| prio_rd | output | 8 | Promotion register readback |
| cfg_we | input | 1 | IRQ configuration write strobe |
| cfg_edge | input | 1 | 1 = falling-edge sensing, 0 = low-level sensing |
| cfg_en | input | 1 | 1 = pin connected to the resolver |
| cfg_rd | output | 2 | {enable, edge} readback |
| pend | output | 1 | A request is being presented |
| vec | output | 16 | Vector address of the winner |

## Verification
Most internal state in this block is visible at the ports within one or two cycles. A wrong promotion value shows up at once on prio_rd. It also puts the wrong winner on vec one cycle after two maskable sources compete. A stuck or missing XIRQ arming flag gives the wrong pend and vec one cycle after the pin falls with ccr_x set. An edge latch that clears early or never clears shows as pend dropping while the pin is high, or staying up after ack, two cycles after the event.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

    localparam logic [7:0] PAGE_HI = 8'hFF;
    localparam logic [7:0] LO_CM   = 8'hFC;
    localparam logic [7:0] LO_COP  = 8'hFA;
    localparam logic [7:0] LO_TRAP = 8'hF8;
    localparam logic [7:0] LO_SWI  = 8'hF6;
    localparam logic [7:0] LO_XIRQ = 8'hF4;
    localparam logic [7:0] LO_IRQ  = 8'hF2;

    // Low address byte of maskable entry j (entry 0 = IRQ pin)
    function automatic logic [7:0] entry_lo(input int j);
        return 8'(LO_IRQ - 8'(2 * j));
    endfunction

    typedef struct packed {
        logic locked;
        logic en;
        logic edge_mode;
        logic prev;
        logic latch;
    } pinctl_t;

    typedef struct packed {
        logic        armed;
        logic        pend;
        logic [15:0] vec;
    } out_t;

endpackage

// File: rtl/ipr_pin_ctl.sv
module ipr_pin_ctl
    import ipr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_n,
    input  logic       cfg_we,
    input  logic       cfg_edge,
    input  logic       cfg_en,
    input  logic       ack_irq,
    output logic       req,
    output logic [1:0] cfg_rd
);

    pinctl_t s_d, s_q;
    logic    fall;

    always_comb begin
        s_d      = s_q;
        s_d.prev = pin_n;
        fall     = s_q.prev & ~pin_n;
        if (cfg_we && !s_q.locked) begin
            s_d.locked    = 1'b1;
            s_d.en        = cfg_en;
            s_d.edge_mode = cfg_edge;
        end
        if (ack_irq) begin
            s_d.latch = 1'b0;
        end
        if (s_q.en && s_q.edge_mode && fall) begin
            s_d.latch = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{locked: 1'b0, en: 1'b1, edge_mode: 1'b0, prev: 1'b1, latch: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req    = s_q.en && (s_q.edge_mode ? s_q.latch : ~pin_n);
    assign cfg_rd = {s_q.en, s_q.edge_mode};

endmodule

// File: rtl/ipr_prio_reg.sv
module ipr_prio_reg
    import ipr_pkg::*;
#(
    parameter int NSRC = 7,
    localparam int NM   = NSRC + 1,
    localparam int IDXW = $clog2(NM)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [7:0]      wdata,
    input  logic            mask_i,
    output logic [7:0]      rd,
    output logic [IDXW-1:0] idx
);

    localparam logic [7:0] LO_MIN = entry_lo(NSRC);

    logic [6:0] q_d, q_q;
    logic [7:0] cand;
    logic       ok;
    logic       unused_bit0;

    assign unused_bit0 = wdata[0];

    always_comb begin
        q_d  = q_q;
        cand = {wdata[7:1], 1'b0};
        ok   = (cand <= LO_IRQ) && (cand >= LO_MIN);
        if (we && mask_i) begin
            q_d = ok ? cand[7:1] : LO_IRQ[7:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= LO_IRQ[7:1];
        end else begin
            q_q <= q_d;
        end
    end

    assign rd  = {q_q, 1'b0};
    assign idx = IDXW'(LO_IRQ[7:1] - q_q);

endmodule

// File: rtl/ipr_resolve.sv
module ipr_resolve
    import ipr_pkg::*;
#(
    parameter int NM = 8,
    localparam int IDXW = $clog2(NM)
) (
    input  logic [NM-1:0]   ent,
    input  logic [IDXW-1:0] prom_idx,
    input  logic            mask_i,
    input  logic            cm,
    input  logic            cop,
    input  logic            trap,
    input  logic            swi,
    input  logic            xirq_live,
    output logic            pend,
    output logic [7:0]      lo
);

    logic prom_hit;

    always_comb begin
        pend     = 1'b1;
        lo       = 8'h00;
        prom_hit = (int'(prom_idx) < NM) && ent[prom_idx];
        if (cm) begin
            lo = LO_CM;
        end else if (cop) begin
            lo = LO_COP;
        end else if (trap) begin
            lo = LO_TRAP;
        end else if (xirq_live) begin
            lo = LO_XIRQ;
        end else if (swi) begin
            lo = LO_SWI;
        end else if (!mask_i && (|ent)) begin
            if (prom_hit) begin
                lo = entry_lo(int'(prom_idx));
            end else begin
                for (int j = NM - 1; j >= 0; j--) begin
                    if (ent[j]) lo = entry_lo(j);
                end
            end
        end else begin
            pend = 1'b0;
        end
    end

endmodule

// File: rtl/ipr_top.sv
module ipr_top
    import ipr_pkg::*;
#(
    parameter int NSRC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_pin_n,
    input  logic            xirq_pin_n,
    input  logic [NSRC-1:0] src_req,
    input  logic            ccr_i,
    input  logic            ccr_x,
    input  logic            cm_req,
    input  logic            cop_req,
    input  logic            trap_req,
    input  logic            swi_req,
    input  logic            ack,
    input  logic            prio_we,
    input  logic [7:0]      prio_wdata,
    output logic [7:0]      prio_rd,
    input  logic            cfg_we,
    input  logic            cfg_edge,
    input  logic            cfg_en,
    output logic [1:0]      cfg_rd,
    output logic            pend,
    output logic [15:0]     vec
);

    localparam int NM   = NSRC + 1;
    localparam int IDXW = $clog2(NM);

    out_t            o_d, o_q;
    logic            irq_req;
    logic            ack_irq;
    logic            xirq_live;
    logic            win_pend;
    logic [7:0]      win_lo;
    logic [IDXW-1:0] prom_idx;
    logic [NM-1:0]   ent;

    assign ack_irq   = ack && o_q.pend && (o_q.vec == {PAGE_HI, LO_IRQ});
    assign xirq_live = ~xirq_pin_n && (~ccr_x || o_q.armed);
    assign ent       = {src_req, irq_req};

    ipr_pin_ctl u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (irq_pin_n),
        .cfg_we  (cfg_we),
        .cfg_edge(cfg_edge),
        .cfg_en  (cfg_en),
        .ack_irq (ack_irq),
        .req     (irq_req),
        .cfg_rd  (cfg_rd)
    );

    ipr_prio_reg #(.NSRC(NSRC)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (prio_we),
        .wdata (prio_wdata),
        .mask_i(ccr_i),
        .rd    (prio_rd),
        .idx   (prom_idx)
    );

    ipr_resolve #(.NM(NM)) u_res (
        .ent      (ent),
        .prom_idx (prom_idx),
        .mask_i   (ccr_i),
        .cm       (cm_req),
        .cop      (cop_req),
        .trap     (trap_req),
        .swi      (swi_req),
        .xirq_live(xirq_live),
        .pend     (win_pend),
        .lo       (win_lo)
    );

    always_comb begin
        o_d       = o_q;
        o_d.armed = o_q.armed | ~ccr_x;
        o_d.pend  = win_pend;
        o_d.vec   = win_pend ? {PAGE_HI, win_lo} : 16'h0000;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign pend = o_q.pend;
    assign vec  = o_q.vec;

endmodule

// File: rtl/ipr_chk.sv
module ipr_chk #(
    parameter int NSRC = 7
) (
    input logic        clk,
    input logic        rst_n,
    input logic        xirq_pin_n,
    input logic        ccr_i,
    input logic        ccr_x,
    input logic        cm_req,
    input logic        cop_req,
    input logic        trap_req,
    input logic        swi_req,
    input logic        prio_we,
    input logic [7:0]  prio_rd,
    input logic        cfg_we,
    input logic [1:0]  cfg_rd,
    input logic        pend,
    input logic [15:0] vec
);

    localparam logic [7:0] LOWEST = 8'(8'hF2 - 8'(2 * NSRC));

    logic x_open_q;
    logic cfg_done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_open_q   <= 1'b0;
            cfg_done_q <= 1'b0;
        end else begin
            x_open_q   <= x_open_q | ~ccr_x;
            cfg_done_q <= cfg_done_q | cfg_we;
        end
    end

    AST_CM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cm_req |=> (pend && vec == 16'hFFFC)); // R2

    AST_XIRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (x_open_q && !xirq_pin_n && !cm_req && !cop_req && !trap_req)
        |=> (pend && vec == 16'hFFF4)); // R3

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ccr_i && xirq_pin_n && !cm_req && !cop_req && !trap_req && !swi_req)
        |=> !pend); // R4

    AST_VEC_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (vec[15:8] == 8'hFF && !vec[0])); // R5

    AST_PRIO_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_we && !ccr_i) |=> $stable(prio_rd)); // R6

    AST_PRIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_rd <= 8'hF2 && prio_rd >= LOWEST)); // R7

    AST_CFG_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done_q && cfg_we) |=> $stable(cfg_rd)); // R9

endmodule

bind ipr_top ipr_chk #(.NSRC(NSRC)) chk_i (.*);

// File: tb/ipr_top_tb_top.sv
module ipr_top_tb_top;

    localparam int NSRC = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            irq_pin_n = 1'b1, xirq_pin_n = 1'b1;
    logic [NSRC-1:0] src_req = '0;
    logic            ccr_i = 1'b1, ccr_x = 1'b1;
    logic            cm_req = 1'b0, cop_req = 1'b0, trap_req = 1'b0, swi_req = 1'b0;
    logic            ack = 1'b0, prio_we = 1'b0, cfg_we = 1'b0;
    logic [7:0]      prio_wdata = '0;
    logic            cfg_edge = 1'b0, cfg_en = 1'b0;
    logic [7:0]      prio_rd;
    logic [1:0]      cfg_rd;
    logic            pend;
    logic [15:0]     vec;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    ipr_top #(.NSRC(NSRC)) dut_i (.*);

    // {i, x, cm cop trap swi, xirq_n, irq_n, src_req[6:0], pend, vec}
    localparam int NROW = 14;
    localparam logic [31:0] TBL [NROW] = '{
        {1'b0, 1'b1, 4'b0000, 1'b1, 1'b1, 7'h00, 1'b0, 16'h0000}, // R4 R5 idle
        {1'b0, 1'b1, 4'b0000, 1'b1, 1'b1, 7'h01, 1'b1, 16'hFFF0}, // R5 tick
        {1'b0, 1'b1, 4'b0000, 1'b1, 1'b1, 7'h40, 1'b1, 16'hFFE4}, // R5 lowest
        {1'b0, 1'b1, 4'b0000, 1'b1, 1'b1, 7'h41, 1'b1, 16'hFFF0}, // R5
        {1'b0, 1'b1, 4'b0000, 1'b1, 1'b0, 7'h01, 1'b1, 16'hFFF2}, // R10 R5
        {1'b1, 1'b1, 4'b0000, 1'b1, 1'b0, 7'h7F, 1'b0, 16'h0000}, // R4
        {1'b1, 1'b1, 4'b0001, 1'b1, 1'b1, 7'h00, 1'b1, 16'hFFF6}, // R2
        {1'b0, 1'b1, 4'b0001, 1'b1, 1'b0, 7'h7F, 1'b1, 16'hFFF6}, // R4
        {1'b1, 1'b1, 4'b0011, 1'b1, 1'b1, 7'h00, 1'b1, 16'hFFF8}, // R2
        {1'b1, 1'b1, 4'b0110, 1'b1, 1'b1, 7'h00, 1'b1, 16'hFFFA}, // R2
        {1'b1, 1'b1, 4'b1100, 1'b1, 1'b1, 7'h00, 1'b1, 16'hFFFC}, // R2
        {1'b0, 1'b1, 4'b0000, 1'b0, 1'b1, 7'h01, 1'b1, 16'hFFF0}, // R3
        {1'b1, 1'b1, 4'b0000, 1'b0, 1'b1, 7'h00, 1'b0, 16'h0000}, // R3
        {1'b0, 1'b1, 4'b0000, 1'b1, 1'b1, 7'h14, 1'b1, 16'hFFEC}  // R5
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_prio(input logic [7:0] v);
        prio_wdata = v;
        prio_we    = 1'b1;
        tick();
        prio_we    = 1'b0;
    endtask

    task automatic wr_cfg(input logic e, input logic en);
        cfg_edge = e;
        cfg_en   = en;
        cfg_we   = 1'b1;
        tick();
        cfg_we   = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 pend", 32'(pend), 32'h0);
        chk("R1 vec", 32'(vec), 32'h0);
        chk("R1 prio_rd", 32'(prio_rd), 32'hF2);
        chk("R1 cfg_rd", 32'(cfg_rd), 32'h2);

        for (int r = 0; r < NROW; r++) begin
            ccr_i      = TBL[r][31];
            ccr_x      = TBL[r][30];
            {cm_req, cop_req, trap_req, swi_req} = TBL[r][29:26];
            xirq_pin_n = TBL[r][25];
            irq_pin_n  = TBL[r][24];
            src_req    = TBL[r][23:17];
            tick();
            chk($sformatf("R2/R3/R4/R5 row %0d", r),
                {15'h0, pend, vec}, {15'h0, TBL[r][16], TBL[r][15:0]});
        end
        {cm_req, cop_req, trap_req, swi_req} = 4'b0;
        xirq_pin_n = 1'b1;
        irq_pin_n  = 1'b1;
        src_req    = '0;

        // promotion register
        ccr_i = 1'b0;
        wr_prio(8'hE8);
        chk("R6 write ignored while I=0", 32'(prio_rd), 32'hF2);
        ccr_i = 1'b1;
        wr_prio(8'hE9);
        chk("R6 bit0 dropped", 32'(prio_rd), 32'hE8);
        ccr_i   = 1'b0;
        src_req = 7'h11;
        tick();
        chk("R8 promoted wins", 32'(vec), 32'hFFE8);
        src_req   = 7'h10;
        irq_pin_n = 1'b0;
        tick();
        chk("R8 promoted over IRQ", 32'(vec), 32'hFFE8);
        src_req   = 7'h01;
        irq_pin_n = 1'b1;
        tick();
        chk("R8 fallback order", 32'(vec), 32'hFFF0);
        src_req = '0;
        ccr_i   = 1'b1;
        wr_prio(8'hE4);
        chk("R6 lowest entry", 32'(prio_rd), 32'hE4);
        wr_prio(8'hFF);
        chk("R7 above F2", 32'(prio_rd), 32'hF2);
        wr_prio(8'hE4);
        wr_prio(8'hE2);
        chk("R7 below lowest", 32'(prio_rd), 32'hF2);

        // XIRQ arming
        ccr_x      = 1'b0;
        xirq_pin_n = 1'b0;
        tick();
        chk("R3 XIRQ open", 32'(vec), 32'hFFF4);
        ccr_x = 1'b1;
        tick();
        chk("R3 XIRQ stays unmasked", 32'(vec), 32'hFFF4);
        swi_req = 1'b1;
        tick();
        chk("R2 XIRQ over SWI", 32'(vec), 32'hFFF4);
        swi_req    = 1'b0;
        xirq_pin_n = 1'b1;
        tick();
        chk("R4 idle after XIRQ", 32'(pend), 32'h0);

        // IRQ config and edge mode
        wr_cfg(1'b1, 1'b1);
        chk("R9 first write", 32'(cfg_rd), 32'h3);
        wr_cfg(1'b0, 1'b0);
        chk("R9 second write ignored", 32'(cfg_rd), 32'h3);
        ccr_i     = 1'b0;
        irq_pin_n = 1'b0;
        tick();
        tick();
        chk("R11 edge seen", {15'h0, pend, vec}, {15'h0, 1'b1, 16'hFFF2});
        irq_pin_n = 1'b1;
        tick();
        tick();
        chk("R11 latch holds", {15'h0, pend, vec}, {15'h0, 1'b1, 16'hFFF2});
        ack = 1'b1;
        tick();
        ack = 1'b0;
        tick();
        chk("R11 cleared by ack", 32'(pend), 32'h0);

        // reset clears arming, disabled pin
        ccr_i = 1'b1;
        do_reset();
        xirq_pin_n = 1'b0;
        tick();
        chk("R3 reset re-masks XIRQ", 32'(pend), 32'h0);
        xirq_pin_n = 1'b1;
        wr_cfg(1'b0, 1'b0);
        chk("R9 disable accepted", 32'(cfg_rd), 32'h0);
        ccr_i     = 1'b0;
        irq_pin_n = 1'b0;
        tick();
        tick();
        chk("R10 disabled pin", 32'(pend), 32'h0);
        irq_pin_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule